// File: doc/BRIEF.md
# Scan-Configured Two-Input Lookup Tile

This tile is the logic element of a very small programmable fabric. It evaluates any Boolean function of two inputs. The function's truth table is stored as four configuration bits. These bits are written and read through a serial scan chain that uses the tile's own clock, so no separate configuration port is needed. When scanning stops, the configuration cells feed their own contents back and keep the loaded table.

In normal operation the two select inputs address one of the four table bits. That bit is registered into the tile output on the rising clock edge. A second register keeps the output value from one cycle earlier, so a small state machine can use the output and its delayed copy. Both output registers are also part of the scan chain. This means test logic can observe them and preset them. A synchronous reset clears the two output registers and leaves the truth table untouched.

Top module: `lut2_scan_tile`

## Requirements
- R1: With `scanEn` low and `rst` low, `lutOut` after a rising edge equals the configuration bit indexed by the value of `selIn` before that edge. Index 0 is {selIn[1],selIn[0]}=00, index 1 is 01, index 2 is 10 and index 3 is 11.
- R2: Outside reset, `lutOutPrev` after each rising edge equals the value `lutOut` had before that edge. This holds in scan mode as well.
- R3: While `scanEn` is low, the four configuration bits keep their values across any number of clocks and any `selIn` activity.
- R4: With `scanEn` high, each edge shifts the chain one place in this order: `scanIn`, then configuration bit 0, 1, 2 and 3, then `lutOut`, then `lutOutPrev`. Of six bits shifted in, the first one ends in `lutOutPrev`.
- R5: `scanOut` always shows the value of `lutOutPrev`, which is the last stage of the chain.
- R6: When `rst` is high at an edge, `lutOut` and `lutOutPrev` read 0 after that edge. If `scanEn` is low, the configuration bits do not change.
- R7: When `rst` and `scanEn` are high at the same edge, the configuration bits still shift by one place from `scanIn`, and both output registers are cleared.
- R8: While `scanEn` is high, `selIn` has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by logic and scan |
| rst | input | 1 | Synchronous active-high clear of the output registers |
| scanEn | input | 1 | High: shift the chain; low: evaluate the table |
| scanIn | input | 1 | Serial input to configuration bit 0 |
| selIn | input | SEL_W | Logic inputs that select a table bit |
| lutOut | output | 1 | Registered table output |
| lutOutPrev | output | 1 | `lutOut` delayed by one cycle |
| scanOut | output | 1 | Serial output of the chain |

## Verification
Reset and scan shifting can both be asserted at the same edge. This is the one case where two functions act on the same registers. The bench provokes it by raising `rst` during an active shift with non-zero bits moving through the chain. It then unloads the chain and checks that the configuration bits moved by one place while both output registers read zero. A behavioural queue model predicts every output on every clock. During scan bursts `selIn` toggles, so any leakage of the select inputs into the shift path would show up.

// File: rtl/lut2_tile_pkg.sv
package lut2_tile_pkg;

  // Strobes from the control decode to the datapath.
  typedef struct packed {
    logic shiftEn;   // every chain stage takes its neighbour
    logic capture;   // output stage loads the selected table bit
    logic clearOut;  // output stages forced to zero
  } tileStrobes_t;

endpackage

// File: rtl/lut2_scan_cell.sv
module lut2_scan_cell (
  input  logic clk,
  input  logic shiftEn,
  input  logic clear,
  input  logic loadEn,
  input  logic scanD,
  input  logic funcD,
  output logic q
);

  logic qReg;

  // Clear wins over shift, shift wins over functional load, otherwise hold.
  always_ff @(posedge clk) begin
    if (clear)        qReg <= 1'b0;
    else if (shiftEn) qReg <= scanD;
    else if (loadEn)  qReg <= funcD;
    else              qReg <= qReg;
  end

  assign q = qReg;

endmodule

// File: rtl/lut2_tile_ctrl.sv
module lut2_tile_ctrl
  import lut2_tile_pkg::*;
(
  input  logic         rst,
  input  logic         scanEn,
  output tileStrobes_t strobes
);

  always_comb begin
    strobes          = '0;
    strobes.shiftEn  = scanEn;
    strobes.capture  = ~scanEn;
    strobes.clearOut = rst;
  end

endmodule

// File: rtl/lut2_tile_dp.sv
module lut2_tile_dp
  import lut2_tile_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  tileStrobes_t     strobes,
  input  logic             scanIn,
  input  logic [SEL_W-1:0] selIn,
  output logic             lutOut,
  output logic             lutOutPrev,
  output logic             scanOut
);

  localparam int NUM_CFG = 1 << SEL_W;

  logic [NUM_CFG-1:0] cfgReg;
  logic [NUM_CFG:0]   cfgChain;   // cfgChain[i] feeds cell i
  logic               pickBit;
  logic               yCur;
  logic               yOld;

  assign cfgChain[0] = scanIn;

  // Configuration cells: never cleared, never loaded, only shift or hold.
  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
    lut2_scan_cell cell_i (
      .clk     (clk),
      .shiftEn (strobes.shiftEn),
      .clear   (1'b0),
      .loadEn  (1'b0),
      .scanD   (cfgChain[i]),
      .funcD   (1'b0),
      .q       (cfgReg[i])
    );
    assign cfgChain[i+1] = cfgReg[i];
  end

  assign pickBit = cfgReg[selIn];

  lut2_scan_cell outCell_i (
    .clk     (clk),
    .shiftEn (strobes.shiftEn),
    .clear   (strobes.clearOut),
    .loadEn  (strobes.capture),
    .scanD   (cfgChain[NUM_CFG]),
    .funcD   (pickBit),
    .q       (yCur)
  );

  lut2_scan_cell prevCell_i (
    .clk     (clk),
    .shiftEn (strobes.shiftEn),
    .clear   (strobes.clearOut),
    .loadEn  (strobes.capture),
    .scanD   (yCur),
    .funcD   (yCur),
    .q       (yOld)
  );

  assign lutOut     = yCur;
  assign lutOutPrev = yOld;
  assign scanOut    = yOld;

endmodule

// File: rtl/lut2_scan_tile.sv
module lut2_scan_tile
  import lut2_tile_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scanEn,
  input  logic             scanIn,
  input  logic [SEL_W-1:0] selIn,
  output logic             lutOut,
  output logic             lutOutPrev,
  output logic             scanOut
);

  tileStrobes_t strobes;

  lut2_tile_ctrl ctrl_i (
    .rst     (rst),
    .scanEn  (scanEn),
    .strobes (strobes)
  );

  lut2_tile_dp #(.SEL_W(SEL_W)) dp_i (
    .clk        (clk),
    .strobes    (strobes),
    .scanIn     (scanIn),
    .selIn      (selIn),
    .lutOut     (lutOut),
    .lutOutPrev (lutOutPrev),
    .scanOut    (scanOut)
  );

endmodule

// File: rtl/lut2_tile_checker.sv
module lut2_tile_checker #(
  parameter int SEL_W = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    scanEn,
  input logic                    scanIn,
  input logic [SEL_W-1:0]        selIn,
  input logic                    lutOut,
  input logic                    lutOutPrev,
  input logic                    scanOut,
  input logic [(1<<SEL_W)-1:0]   cfgBits
);

  localparam int NUM_CFG = 1 << SEL_W;

  logic                 seenEdge = 1'b0;
  logic                 lastRst;
  logic                 lastScan;
  logic                 lastScanIn;
  logic [NUM_CFG-1:0]   lastCfg;

  always_ff @(posedge clk) begin
    seenEdge   <= 1'b1;
    lastRst    <= rst;
    lastScan   <= scanEn;
    lastScanIn <= scanIn;
    lastCfg    <= cfgBits;
  end

  // Checked at the falling edge, where both the snapshots and the outputs are settled.
  always @(negedge clk) begin
    if (seenEdge && lastRst) begin
      assert_reset_clears_R6: assert (lutOut == 1'b0 && lutOutPrev == 1'b0);
      if (!lastScan) begin
        assert_reset_keeps_cfg_R6: assert (cfgBits == lastCfg);
      end else begin
        assert_reset_shift_R7: assert (cfgBits == {lastCfg[NUM_CFG-2:0], lastScanIn});
      end
    end
  end

  assert_lut_pick_R1: assert property (@(posedge clk) disable iff (rst)
    !scanEn |=> lutOut == $past(cfgBits[selIn]));

  assert_prev_tracks_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> lutOutPrev == $past(lutOut));

  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !scanEn |=> $stable(cfgBits));

  assert_shift_entry_R4: assert property (@(posedge clk) disable iff (rst)
    scanEn |=> cfgBits[0] == $past(scanIn));

  assert_shift_to_out_R8: assert property (@(posedge clk) disable iff (rst)
    scanEn |=> lutOut == $past(cfgBits[NUM_CFG-1]));

  assert_serial_out_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> scanOut == $past(lutOut));

endmodule

bind lut2_scan_tile lut2_tile_checker #(.SEL_W(SEL_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .scanEn     (scanEn),
  .scanIn     (scanIn),
  .selIn      (selIn),
  .lutOut     (lutOut),
  .lutOutPrev (lutOutPrev),
  .scanOut    (scanOut),
  .cfgBits    (dp_i.cfgReg)
);

// File: tb/lut2_scan_tile_tb_top.sv
module lut2_scan_tile_tb_top;

  localparam int NCFG = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scanEn = 1'b0;
  logic       scanIn = 1'b0;
  logic [1:0] selIn = 2'b00;
  logic       lutOut, lutOutPrev, scanOut;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;
  // Model chain: [0..3] table bits, [4] output, [5] delayed output.
  bit  mChain[$];

  always #2 clk = ~clk;

  lut2_scan_tile dut_i (
    .clk(clk), .rst(rst), .scanEn(scanEn), .scanIn(scanIn), .selIn(selIn),
    .lutOut(lutOut), .lutOutPrev(lutOutPrev), .scanOut(scanOut)
  );

  task automatic check1(string tag, string what, logic act, bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(bit r, bit se, bit si, bit [1:0] sel, bit chk, string tag);
    bit yNew;
    @(negedge clk);
    rst = r; scanEn = se; scanIn = si; selIn = sel;
    @(posedge clk);
    if (se) begin
      mChain.push_front(si);
      void'(mChain.pop_back());
      if (r) begin mChain[NCFG] = 1'b0; mChain[NCFG+1] = 1'b0; end
    end else begin
      yNew = r ? 1'b0 : mChain[sel];
      mChain[NCFG+1] = r ? 1'b0 : mChain[NCFG];
      mChain[NCFG] = yNew;
    end
    #1;
    if (chk) begin
      check1(tag, "lutOut", lutOut, mChain[NCFG]);
      check1(r ? tag : "R2", "lutOutPrev", lutOutPrev, mChain[NCFG+1]);
      check1("R5", "scanOut", scanOut, mChain[NCFG+1]);
    end
  endtask

  task automatic loadTable(bit [3:0] tbl, bit chk, string tag);
    // Table bit 3 goes in first; after four shifts bit i sits in cell i.
    for (int i = NCFG - 1; i >= 0; i--) step(0, 1, tbl[i], 2'(i * 3), chk, tag);
  endtask

  task automatic allPatterns(string tag);
    for (int rep = 0; rep < 2; rep++)
      for (int s = 0; s < 4; s++) step(0, 0, 1'b1, 2'(s), 1, tag);
    step(0, 0, 0, 2'b11, 1, tag);
    step(0, 0, 0, 2'b00, 1, tag);
    step(0, 0, 0, 2'b10, 1, tag);
  endtask

  initial begin
    for (int i = 0; i < NCFG + 2; i++) mChain.push_back(1'b0);
    // Reset: outputs clear, table unknown.
    for (int i = 0; i < 3; i++) step(1, 0, 0, 2'(i), 1, "R6");
    // Fill all six stages unchecked so the model becomes exact.
    for (int i = 0; i < NCFG + 2; i++) step(0, 1, 1'(i & 1), 2'b00, 0, "R4");
    // XOR table: index 1 and 2 high.
    loadTable(4'b0110, 1, "R4");
    allPatterns("R1");
    // Long hold with select activity, then unload through the chain.
    for (int i = 0; i < 10; i++) step(0, 0, 1'b1, 2'(i), 1, "R3");
    for (int i = 0; i < NCFG + 2; i++) step(0, 1, 0, 2'(i), 1, "R3");
    // AND table loaded with select toggling during the shift.
    loadTable(4'b1000, 1, "R8");
    for (int i = 0; i < 2; i++) step(0, 1, 1'(i), 2'(3 - i), 1, "R8");
    for (int i = 0; i < NCFG + 2; i++) step(0, 1, 1'(i % 3 == 0), 2'(i), 1, "R4");
    loadTable(4'b1101, 1, "R4");
    allPatterns("R1");
    // Reset without scan: table must survive.
    step(1, 0, 1, 2'b01, 1, "R6");
    step(1, 0, 0, 2'b10, 1, "R6");
    allPatterns("R6");
    // Reset during a shift: table moves, outputs clear.
    loadTable(4'b1011, 1, "R4");
    step(0, 1, 1, 2'b00, 1, "R7");
    step(1, 1, 0, 2'b11, 1, "R7");
    step(1, 1, 1, 2'b01, 1, "R7");
    for (int i = 0; i < NCFG + 2; i++) step(0, 1, 0, 2'(i), 1, "R7");
    loadTable(4'b0001, 1, "R4");
    allPatterns("R1");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule